// File: doc/BRIEF.md
# Single-Correct Double-Detect Block Decoder with Sample Concealment

This block takes 63-bit protected words, each carrying 56 payload bits and 7 check bits, and recovers the payload. One flipped bit anywhere in the word is repaired. Two flipped bits are recognised as uncorrectable and flagged. The corrected payload and its status flags appear a fixed two cycles after the word is presented.

The payload is treated as a group of audio samples, called lanes, that share one protection word. A second output stream carries the audio after concealment. A word that the decoder marks uncorrectable is not passed to the audio stream. Each of its lanes is replaced instead, in one of two ways chosen by a mode input. Hold mode repeats the most recent trustworthy sample. Interpolate mode takes the midpoint between that sample and the one that follows. The following sample has to be known first, so the audio stream always runs exactly one word behind the decoded stream. This holds in both modes, which keeps the timing uniform.

Top module: `bch_sec_ded_conceal`

## Requirements
- R1: While `rst_n` is low at a clock edge, every valid and flag output is low after that edge, and the concealment history (held word and last trustworthy word) is cleared to zero.
- R2: Layout and timing: bit j of `in_code` is the coefficient of x^j. The payload sits in bits 62..7 and the check bits in 6..0, so the whole word is divisible by x^7+x^6+x^2+1. `dec_valid` is high for one cycle, two clock edges after the edge that samples `in_valid` high.
- R3: A word with no flipped bits yields its payload on `dec_data`, with `dec_single`, `dec_double` and `dec_err` all low.
- R4: A word with exactly one flipped bit, at any of the 63 positions, yields the original payload with `dec_single` high and `dec_double` low.
- R5: A word with exactly two flipped bits raises `dec_double`, leaves `dec_single` low, and passes the received payload bits through unaltered.
- R6: If the check sum over the field is zero but the overall parity is odd, the received payload passes through unaltered and `dec_single` is raised. An example is flips at positions 0, 1 and 6.
- R7: `dec_err` is high exactly when `dec_single` or `dec_double` is high.
- R8: Word n appears on `aud_data` with `aud_valid` high for one cycle, one edge after `dec_valid` for word n+1. If word n had no double error, `aud_data` equals its decoded payload and `aud_concealed` is low. The final word stays held until another word arrives.
- R9: When `conceal_mode` is 0, a word with a double error is output as the last trustworthy word, with `aud_concealed` high.
- R10: When `conceal_mode` is 1 and the next word has no double error, each lane of a word with a double error becomes floor((prev+next)/2). Lane k is bits k*14 to k*14+13 of the payload, read as two's complement. Here prev is that lane of the last trustworthy word and next is that lane of the following decoded word. When the following word also has a double error, the hold value of R9 is used instead.
- R11: `conceal_mode` is sampled at the cycle in which the concealed word is emitted, not when that word was received.
- R12: Only words without a double error update the last trustworthy word. Concealed output values never become a reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: `in_code` holds a word this cycle |
| in_code | input | 63 | Received protected word |
| conceal_mode | input | 1 | 0 = hold, 1 = interpolate |
| dec_valid | output | 1 | Decoded word present |
| dec_data | output | 56 | Corrected payload |
| dec_single | output | 1 | Single error corrected (or odd parity with zero check sum) |
| dec_double | output | 1 | Uncorrectable double error detected |
| dec_err | output | 1 | Any error detected |
| aud_valid | output | 1 | Audio word present |
| aud_data | output | 56 | Audio payload after concealment |
| aud_concealed | output | 1 | The present audio word was substituted |

## Verification
The bench builds the block with its default lane split of four lanes of 14 bits. At that split the payload fills all 56 bits, so flips at either end of the payload range are exercised. Lane sign bits fall inside the hex patterns, which brings negative-sample midpoints and floor rounding within reach. The triple-flip pattern at positions 0, 1 and 6 produces the zero-sum, odd-parity case of R6. Runs of consecutive double errors exercise the fallback from interpolation to hold.

// File: rtl/bch_pkg.sv
// Package: field constants and the multiply-by-alpha step for GF(2^6)
// built on x^6+x+1. Assumes the code length 63, payload 56.
package bch_pkg;
    localparam int CODE_N = 63;
    localparam int DATA_K = 56;
    localparam int PAR_W  = CODE_N - DATA_K;
    localparam int SYN_W  = 6;
    // low part of the field polynomial: alpha^6 = alpha + 1
    localparam logic [SYN_W-1:0] FIELD_LOW = 6'b000011;

    // Multiply a field element by alpha.
    function automatic logic [SYN_W-1:0] gf_mul_alpha(input logic [SYN_W-1:0] v);
        logic [SYN_W-1:0] r;
        r = {v[SYN_W-2:0], 1'b0};
        if (v[SYN_W-1]) r = r ^ FIELD_LOW;
        return r;
    endfunction

    // Stage-one result: field check sum, overall parity, payload bits.
    typedef struct packed {
        logic [SYN_W-1:0]  syn;
        logic              par;
        logic [DATA_K-1:0] data;
    } syn_word_t;
endpackage

// File: rtl/bch_syndrome.sv
// Stage one: evaluates the received word at alpha (6-bit field check sum)
// and forms its overall parity. Registers the result with the payload.
// Assumes bit j of the word is the coefficient of x^j.
module bch_syndrome
    import bch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CODE_N-1:0] in_code,
    output logic              s_valid,
    output syn_word_t         s_word
);
    logic [SYN_W-1:0] syn_c;
    logic [SYN_W-1:0] pw;
    logic             par_c;

    // Sum alpha^j over every set bit j of the received word.
    always_comb begin
        pw    = {{(SYN_W-1){1'b0}}, 1'b1};
        syn_c = '0;
        for (int j = 0; j < CODE_N; j++) begin
            if (in_code[j]) syn_c = syn_c ^ pw;
            pw = gf_mul_alpha(pw);
        end
        par_c = ^in_code;
    end

    // Capture the check results and payload for stage two.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid <= 1'b0;
            s_word  <= '0;
        end else begin
            s_valid <= in_valid;
            if (in_valid) begin
                s_word.syn  <= syn_c;
                s_word.par  <= par_c;
                s_word.data <= in_code[CODE_N-1:PAR_W];
            end
        end
    end
endmodule

// File: rtl/bch_correct.sv
// Stage two: turns the check sum into a one-hot error position, flips that
// bit when parity says a single error occurred, and classifies the word.
// Assumes stage one delivered sum and parity over all 63 bits.
module bch_correct
    import bch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  syn_word_t         s_word,
    output logic              dec_valid,
    output logic [DATA_K-1:0] dec_data,
    output logic              dec_single,
    output logic              dec_double
);
    logic [CODE_N-1:0] err_mask;
    logic [SYN_W-1:0]  pw;
    logic              syn_nz;
    logic              fix_en;

    // Match the check sum against alpha^j for every position j.
    always_comb begin
        pw = {{(SYN_W-1){1'b0}}, 1'b1};
        for (int j = 0; j < CODE_N; j++) begin
            err_mask[j] = (s_word.syn == pw);
            pw = gf_mul_alpha(pw);
        end
        syn_nz = |s_word.syn;
        fix_en = syn_nz & s_word.par;
    end

    // Register the corrected payload and the error class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_data   <= '0;
            dec_single <= 1'b0;
            dec_double <= 1'b0;
        end else begin
            dec_valid <= s_valid;
            if (s_valid) begin
                dec_data   <= fix_en ? (s_word.data ^ err_mask[CODE_N-1:PAR_W])
                                     : s_word.data;
                dec_single <= s_word.par;
                dec_double <= syn_nz & ~s_word.par;
            end else begin
                dec_single <= 1'b0;
                dec_double <= 1'b0;
            end
        end
    end

    // R4
    one_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err_mask));

    // R5
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> !(dec_single && dec_double));
endmodule

// File: rtl/conceal_unit.sv
// Concealment: holds one decoded word until the next arrives, then emits it,
// substituting words flagged uncorrectable by either the last trustworthy
// word (hold) or the per-lane midpoint with the following word.
// Assumes LANE_W*NUM_LANES equals the payload width.
module conceal_unit #(
    parameter int LANE_W    = 14,
    parameter int NUM_LANES = 4,
    localparam int WORD_W   = LANE_W * NUM_LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_interp,
    input  logic              dec_valid,
    input  logic [WORD_W-1:0] dec_data,
    input  logic              dec_bad,
    output logic              aud_valid,
    output logic [WORD_W-1:0] aud_data,
    output logic              aud_concealed
);
    logic              held_valid;
    logic [WORD_W-1:0] held_data;
    logic              held_bad;
    logic [WORD_W-1:0] last_good;
    logic [WORD_W-1:0] mid_word;
    logic [WORD_W-1:0] subst;
    logic [WORD_W-1:0] emit_word;

    // Per-lane floor midpoint of last trustworthy and incoming sample.
    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        logic [LANE_W-1:0]        a_s;
        logic [LANE_W-1:0]        b_s;
        logic signed [LANE_W-1:0] a_h;
        logic signed [LANE_W-1:0] b_h;
        // Halve each sample arithmetically and restore the common carry.
        always_comb begin
            a_s = last_good[k*LANE_W +: LANE_W];
            b_s = dec_data[k*LANE_W +: LANE_W];
            a_h = $signed(a_s) >>> 1;
            b_h = $signed(b_s) >>> 1;
            mid_word[k*LANE_W +: LANE_W] = a_h + b_h
                + {{(LANE_W-1){1'b0}}, a_s[0] & b_s[0]};
        end
    end

    // Choose the value emitted for the held word.
    always_comb begin
        subst     = (mode_interp && !dec_bad) ? mid_word : last_good;
        emit_word = held_bad ? subst : held_data;
    end

    // Advance the one-word delay line on each decoded word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_valid    <= 1'b0;
            held_data     <= '0;
            held_bad      <= 1'b0;
            last_good     <= '0;
            aud_valid     <= 1'b0;
            aud_data      <= '0;
            aud_concealed <= 1'b0;
        end else begin
            aud_valid     <= 1'b0;
            aud_concealed <= 1'b0;
            if (dec_valid) begin
                aud_valid     <= held_valid;
                aud_data      <= emit_word;
                aud_concealed <= held_valid & held_bad;
                if (held_valid && !held_bad) last_good <= held_data;
                held_valid <= 1'b1;
                held_data  <= dec_data;
                held_bad   <= dec_bad;
            end
        end
    end

    // R8
    emit_after_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aud_valid |-> $past(dec_valid));

    // R9
    concealed_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aud_concealed |-> aud_valid);
endmodule

// File: rtl/bch_sec_ded_conceal.sv
// Top: two-stage single-correct double-detect decoder feeding a one-word
// concealment stage. Assumes words arrive no faster than one per cycle.
module bch_sec_ded_conceal
    import bch_pkg::*;
#(
    parameter int LANE_W    = 14,
    parameter int NUM_LANES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CODE_N-1:0] in_code,
    input  logic              conceal_mode,
    output logic              dec_valid,
    output logic [DATA_K-1:0] dec_data,
    output logic              dec_single,
    output logic              dec_double,
    output logic              dec_err,
    output logic              aud_valid,
    output logic [DATA_K-1:0] aud_data,
    output logic              aud_concealed
);
    logic      s_valid;
    syn_word_t s_word;

    bch_syndrome u_syn (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_code  (in_code),
        .s_valid  (s_valid),
        .s_word   (s_word)
    );

    bch_correct u_fix (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_valid    (s_valid),
        .s_word     (s_word),
        .dec_valid  (dec_valid),
        .dec_data   (dec_data),
        .dec_single (dec_single),
        .dec_double (dec_double)
    );

    conceal_unit #(
        .LANE_W    (LANE_W),
        .NUM_LANES (NUM_LANES)
    ) u_hide (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_interp   (conceal_mode),
        .dec_valid     (dec_valid),
        .dec_data      (dec_data),
        .dec_bad       (dec_double),
        .aud_valid     (aud_valid),
        .aud_data      (aud_data),
        .aud_concealed (aud_concealed)
    );

    // Any error class raises the summary flag.
    always_comb dec_err = dec_single | dec_double;

    // R2
    fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 dec_valid);
endmodule

// File: tb/bch_sec_ded_conceal_tb_top.sv
module bch_sec_ded_conceal_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 14;
    localparam int NL = 4;
    localparam logic [6:0] NONE = 7'h7F;

    typedef struct packed {
        logic [55:0] data;
        logic [6:0]  e1;
        logic [6:0]  e2;
        logic        mode;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{56'h0123_4567_89AB_CD, NONE,  NONE,  1'b0},
        '{56'hFEDC_BA98_7654_32, 7'd62, NONE,  1'b0},
        '{56'h1111_2222_3333_44, 7'd10, 7'd40, 1'b0},
        '{56'h0000_0000_0000_00, 7'd7,  NONE,  1'b0},
        '{56'h7FFF_8000_1234_56, 7'd0,  NONE,  1'b1},
        '{56'hAAAA_5555_AAAA_55, 7'd3,  7'd50, 1'b1},
        '{56'h3FFF_C000_0001_FF, NONE,  NONE,  1'b1},
        '{56'h8000_0000_0000_01, 7'd20, 7'd21, 1'b1},
        '{56'h5A5A_5A5A_5A5A_5A, 7'd55, 7'd56, 1'b1},
        '{56'hC3C3_C3C3_C3C3_C3, 7'd33, NONE,  1'b1},
        '{56'h0F0F_0F0F_0F0F_0F, 7'd1,  7'd62, 1'b0},
        '{56'h2468_ACE0_1357_9B, NONE,  NONE,  1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [62:0] in_code = '0;
    logic        conceal_mode = 1'b0;
    logic        dec_valid, dec_single, dec_double, dec_err;
    logic [55:0] dec_data, aud_data;
    logic        aud_valid, aud_concealed;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic        m_held_valid;
    logic [55:0] m_held_data;
    logic        m_held_bad;
    logic [55:0] m_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    bch_sec_ded_conceal #(.LANE_W(LW), .NUM_LANES(NL)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
        .conceal_mode(conceal_mode), .dec_valid(dec_valid), .dec_data(dec_data),
        .dec_single(dec_single), .dec_double(dec_double), .dec_err(dec_err),
        .aud_valid(aud_valid), .aud_data(aud_data), .aud_concealed(aud_concealed)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Division by x^7+x^6+x^2+1 gives the check bits.
    function automatic logic [62:0] encode(input logic [55:0] d);
        logic [6:0] r;
        logic fb;
        r = '0;
        for (int i = 55; i >= 0; i--) begin
            fb = d[i] ^ r[6];
            r = {r[5:0], 1'b0};
            if (fb) r = r ^ 7'h45;
        end
        return {d, r};
    endfunction

    function automatic logic [55:0] midpoint(input logic [55:0] a, input logic [55:0] b);
        logic [55:0] m;
        for (int k = 0; k < NL; k++) begin
            int sa = int'($signed(a[k*LW +: LW]));
            int sb = int'($signed(b[k*LW +: LW]));
            int s  = (sa + sb) >>> 1;
            m[k*LW +: LW] = s[LW-1:0];
        end
        return m;
    endfunction

    task automatic model_reset();
        m_held_valid = 0; m_held_data = '0; m_held_bad = 0; m_last = '0;
    endtask

    task automatic send(input logic [55:0] d, input logic [62:0] emask, input logic mode,
                        input bit x_single, input bit x_double, input logic [55:0] x_data,
                        input string tag);
        logic [62:0] cw;
        logic [55:0] x_aud;
        cw = encode(d) ^ emask;
        @(negedge clk);
        in_valid = 1; in_code = cw; conceal_mode = mode;
        @(negedge clk);
        in_valid = 0;
        @(negedge clk);
        // R2 R3 R4 R5 R6 R7: decoded outputs two edges after the strobe
        check(dec_valid === 1'b1, {tag, " R2 dec_valid"}, 64'(dec_valid), 64'd1);
        check(dec_data === x_data, {tag, " dec_data"}, 64'(dec_data), 64'(x_data));
        check(dec_single === x_single, {tag, " dec_single"}, 64'(dec_single), 64'(x_single));
        check(dec_double === x_double, {tag, " dec_double"}, 64'(dec_double), 64'(x_double));
        check(dec_err === (x_single | x_double), {tag, " R7 dec_err"},
              64'(dec_err), 64'(x_single | x_double));
        @(negedge clk);
        // R8 R9 R10 R11 R12: audio word for the previously held decoded word
        if (m_held_valid) begin
            if (m_held_bad) x_aud = (mode && !x_double) ? midpoint(m_last, x_data) : m_last;
            else            x_aud = m_held_data;
            check(aud_valid === 1'b1, {tag, " R8 aud_valid"}, 64'(aud_valid), 64'd1);
            check(aud_data === x_aud, {tag, " R8 R9 R10 aud_data"}, 64'(aud_data), 64'(x_aud));
            check(aud_concealed === m_held_bad, {tag, " R9 aud_concealed"},
                  64'(aud_concealed), 64'(m_held_bad));
            if (!m_held_bad) m_last = m_held_data;
        end else begin
            check(aud_valid === 1'b0, {tag, " R8 no aud"}, 64'(aud_valid), 64'd0);
        end
        m_held_valid = 1; m_held_data = x_data; m_held_bad = x_double;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; in_valid = 0;
        repeat (3) @(negedge clk);
        // R1: reset state of all valid and flag outputs
        check(dec_valid === 1'b0, "R1 dec_valid", 64'(dec_valid), 64'd0);
        check(dec_err === 1'b0, "R1 dec_err", 64'(dec_err), 64'd0);
        check(aud_valid === 1'b0, "R1 aud_valid", 64'(aud_valid), 64'd0);
        check(aud_concealed === 1'b0, "R1 aud_concealed", 64'(aud_concealed), 64'd0);
        rst_n = 1;
        model_reset();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [62:0] em;
        int cnt;
        logic [55:0] xd;
        do_reset();

        // Table walk: clean, single, double words in both modes
        for (int i = 0; i < 12; i++) begin
            em = '0; cnt = 0;
            if (VECS[i].e1 != NONE) begin em[VECS[i].e1] = 1'b1; cnt++; end
            if (VECS[i].e2 != NONE) begin em[VECS[i].e2] = 1'b1; cnt++; end
            xd = (cnt == 2) ? (encode(VECS[i].data) ^ em) >> 7 : VECS[i].data;
            send(VECS[i].data, em, VECS[i].mode, cnt == 1, cnt == 2, xd,
                 $sformatf("vec%0d", i));
        end

        // R6: zero field sum, odd parity (flips 0,1,6 all in check bits)
        em = '0; em[0] = 1; em[1] = 1; em[6] = 1;
        send(56'h1357_9BDF_0246_8A, em, 1'b0, 1'b1, 1'b0, 56'h1357_9BDF_0246_8A, "R6 triple");

        // R4: every single position
        for (int p = 0; p < 63; p++) begin
            em = '0; em[p] = 1'b1;
            send(56'h9E37_79B9_7F4A_7C ^ 56'(p), em, 1'b0, 1'b1, 1'b0,
                 56'h9E37_79B9_7F4A_7C ^ 56'(p), $sformatf("R4 pos%0d", p));
        end

        // R11: bad word sent in hold mode, emitted while interpolate is selected
        em = '0; em[12] = 1; em[44] = 1;
        xd = (encode(56'h0000_1111_2222_33) ^ em) >> 7;
        send(56'h0000_1111_2222_33, em, 1'b0, 1'b0, 1'b1, xd, "R11 bad");
        send(56'hFFFF_0000_FFFF_00, '0, 1'b1, 1'b0, 1'b0, 56'hFFFF_0000_FFFF_00, "R11 next");

        // R1 R9 R12: after reset the hold reference is zero
        do_reset();
        em = '0; em[30] = 1; em[31] = 1;
        xd = (encode(56'h7654_3210_FEDC_BA) ^ em) >> 7;
        send(56'h7654_3210_FEDC_BA, em, 1'b0, 1'b0, 1'b1, xd, "R9 first bad");
        send(56'h0102_0304_0506_07, '0, 1'b0, 1'b0, 1'b0, 56'h0102_0304_0506_07, "R9 after");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule